// File: doc/BRIEF.md
# CAN-FD Transmitter Delay Compensation Unit

While a node sends in the fast data phase of a CAN-FD frame, the level it reads back from the transceiver lags its own TX pin by the loop delay through the transceiver. This unit finds that lag in system clocks and places a secondary sample point that late. From there the received level can be compared with the transmitted one. A measurement runs when the TX bit timing logic marks the start of a bit on which TX goes from recessive to dominant. It ends on the first clock that RX reads dominant.

An effective delay comes from the configuration. In automatic mode it is the measured delay plus a signed offset. In manual mode the offset alone, read as unsigned, is the delay. In the other two modes the delay is zero. The effective delay is added to the data-phase sample point offset, which counts clocks from the bit start to the normal sample point. The sum is clamped at zero and stored for each bit start. The unit then raises a one-clock strobe that many clocks later and captures RX at that moment. Several bit starts can wait for their strobes at the same time, so a loop delay longer than one data bit still works.

Top module: `tdc_unit`

## Requirements
- R1: After reset `meas_o` is 0, `meas_err_o` is 0, `ssp_stb_o` is 0 and `rx_bit_o` is 1 (recessive).
- R2: A measurement starts only in a cycle where `bit_start_i` is 1, `tx_i` is 0 (dominant) and `tx_i` was 1 (recessive) in the previous cycle. A TX level held dominant across bit starts does not start one.
- R3: The measured delay is the number of cycles from the start cycle (counted as 0) to the first cycle in which `rx_i` is 0. `meas_o` shows it from the next cycle on.
- R4: If `rx_i` is still 1 in the cycle where the count is 63, the measurement ends. `meas_err_o` becomes 1 in the next cycle and `meas_o` keeps its old value. A successful measurement clears `meas_err_o`.
- R5: A new start condition during a running measurement restarts the count from 0.
- R6: With `mode_i` = 2'b00 (automatic), the effective delay is `meas_o` plus `tdc_ofs_i` read as 6-bit two's complement.
- R7: With `mode_i` = 2'b01 (manual), the effective delay is `tdc_ofs_i` read as unsigned. The measurement keeps running but is not used.
- R8: With `mode_i` = 2'b11 (off) or 2'b10 (reserved), the effective delay is 0 and `tdc_ofs_i` has no effect. The strobe lands at the plain data-phase sample point.
- R9: The secondary sample position is the effective delay plus `sp_ofs_i`. A negative sum is clamped to 0.
- R10: For a `bit_start_i` in cycle t, with position P computed from the inputs and `meas_o` of cycle t, `ssp_stb_o` is 1 in cycle t+P+1.
- R11: `rx_bit_o` takes the value of `rx_i` from a cycle in which `ssp_stb_o` is 1. It shows that value from the next cycle and holds it until the next strobe.
- R12: Up to NSLOT (default 4) bit starts can wait for their strobes at once. A slot whose strobe fires in a cycle is free again in that same cycle. A bit start that finds no free slot produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_i | input | 1 | TX line level, 0 = dominant |
| rx_i | input | 1 | RX line level, 0 = dominant |
| bit_start_i | input | 1 | One-cycle pulse at each transmitted bit start |
| sp_ofs_i | input | 8 | Data-phase sample point offset in clocks from bit start |
| mode_i | input | 2 | 00 auto, 01 manual, 10 reserved, 11 off |
| tdc_ofs_i | input | 6 | Compensation offset (signed in auto, unsigned in manual) |
| meas_o | output | 6 | Last valid measured loop delay in clocks |
| meas_err_o | output | 1 | Last measurement timed out |
| ssp_stb_o | output | 1 | One-cycle secondary sample point strobe |
| rx_bit_o | output | 1 | RX level captured at the last strobe |

## Verification
`meas_o` and `meas_err_o` change one cycle after the cycle in which RX reads dominant or the count reaches its limit. The strobe rises P+1 cycles after its bit start, and `rx_bit_o` follows one cycle after the strobe. The bench models these delays directly. It keeps a list of remaining cycle counts for pending strobes and a delay-line model of the transceiver. It steps this model once per clock with the same inputs the design sees. All four outputs are compared at the falling edge, halfway between the clock edges that update them, so each expected value is read in exactly the cycle it is due.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  // Line levels: dominant drives the bus low.
  localparam logic LVL_DOM = 1'b0;
  localparam logic LVL_REC = 1'b1;

  typedef enum logic [1:0] {
    TDC_AUTO   = 2'b00,
    TDC_MANUAL = 2'b01,
    TDC_RSVD   = 2'b10,
    TDC_OFF    = 2'b11
  } tdc_mode_e;
endpackage

// File: rtl/tdc_meas.sv
// Loop delay measurement: counts from a dominant bit start on TX until
// RX reads dominant, saturating at the counter maximum.
module tdc_meas
  import tdc_pkg::*;
#(
  parameter int MEAS_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_i,
  input  logic              rx_i,
  input  logic              bit_start_i,
  output logic [MEAS_W-1:0] meas_o,
  output logic              err_o
);
  localparam logic [MEAS_W-1:0] CNT_MAX = '1;
  localparam logic [MEAS_W-1:0] CNT_ONE = MEAS_W'(1);

  logic              txq_q, txq_d;
  logic              act_q, act_d;
  logic              err_q, err_d;
  logic [MEAS_W-1:0] cnt_q, cnt_d;
  logic [MEAS_W-1:0] meas_q, meas_d;
  logic              meas_en;
  logic              start_c;

  assign start_c = bit_start_i && (tx_i == LVL_DOM) && (txq_q == LVL_REC);

  always_comb begin
    txq_d   = tx_i;
    act_d   = act_q;
    err_d   = err_q;
    cnt_d   = cnt_q;
    meas_d  = meas_q;
    meas_en = 1'b0;
    if (start_c) begin
      if (rx_i == LVL_DOM) begin
        meas_d  = '0;
        meas_en = 1'b1;
        err_d   = 1'b0;
        act_d   = 1'b0;
        cnt_d   = '0;
      end else begin
        act_d = 1'b1;
        cnt_d = CNT_ONE;
      end
    end else if (act_q) begin
      if (rx_i == LVL_DOM) begin
        meas_d  = cnt_q;
        meas_en = 1'b1;
        err_d   = 1'b0;
        act_d   = 1'b0;
      end else if (cnt_q == CNT_MAX) begin
        err_d = 1'b1;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txq_q  <= LVL_REC;
      act_q  <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      meas_q <= '0;
    end else begin
      txq_q <= txq_d;
      act_q <= act_d;
      err_q <= err_d;
      cnt_q <= cnt_d;
      if (meas_en) begin
        meas_q <= meas_d;
      end
    end
  end

  assign meas_o = meas_q;
  assign err_o  = err_q;
endmodule

// File: rtl/tdc_ssp_calc.sv
// Combinational secondary sample point position from mode, offset,
// measured delay and data-phase sample point offset.
module tdc_ssp_calc
  import tdc_pkg::*;
#(
  parameter int MEAS_W = 6,
  parameter int OFS_W  = 6,
  parameter int SPO_W  = 8,
  localparam int MAX_W = (SPO_W > MEAS_W) ? ((SPO_W > OFS_W) ? SPO_W : OFS_W)
                                          : ((MEAS_W > OFS_W) ? MEAS_W : OFS_W),
  localparam int SUM_W = MAX_W + 3,
  localparam int SSP_W = SUM_W - 1
) (
  input  logic [1:0]        mode_i,
  input  logic [MEAS_W-1:0] meas_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [SPO_W-1:0]  spo_i,
  output logic [SSP_W-1:0]  ssp_o
);
  logic signed [SUM_W-1:0] meas_x;
  logic signed [SUM_W-1:0] ofs_s;
  logic signed [SUM_W-1:0] ofs_u;
  logic signed [SUM_W-1:0] spo_x;
  logic signed [SUM_W-1:0] eff;
  logic signed [SUM_W-1:0] tot;

  assign meas_x = signed'({{(SUM_W-MEAS_W){1'b0}}, meas_i});
  assign ofs_s  = signed'({{(SUM_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i});
  assign ofs_u  = signed'({{(SUM_W-OFS_W){1'b0}}, ofs_i});
  assign spo_x  = signed'({{(SUM_W-SPO_W){1'b0}}, spo_i});

  always_comb begin
    case (tdc_mode_e'(mode_i))
      TDC_AUTO:   eff = meas_x + ofs_s;
      TDC_MANUAL: eff = ofs_u;
      default:    eff = '0;
    endcase
    tot = eff + spo_x;
    if (tot[SUM_W-1]) begin
      ssp_o = '0;
    end else begin
      ssp_o = tot[SSP_W-1:0];
    end
  end
endmodule

// File: rtl/tdc_ssp_sched.sv
// Pending strobe slots: each bit start loads a free slot with its sample
// position; the slot counts down and fires the strobe at zero.
module tdc_ssp_sched
  import tdc_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int CW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_start_i,
  input  logic [CW-1:0] ssp_i,
  input  logic          rx_i,
  output logic          stb_o,
  output logic          rx_bit_o
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [NSLOT-1:0] busy_q, busy_d;
  logic [NSLOT-1:0] fire_c;
  logic [CW-1:0]    cnt_q [NSLOT];
  logic [CW-1:0]    cnt_d [NSLOT];
  logic             rxb_q, rxb_en;

  for (genvar g = 0; g < NSLOT; g++) begin : g_fire
    assign fire_c[g] = busy_q[g] && (cnt_q[g] == '0);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      busy_d[i] = busy_q[i] && !fire_c[i];
      cnt_d[i]  = busy_d[i] ? (cnt_q[i] - CNT_ONE) : cnt_q[i];
    end
    for (int i = 0; i < NSLOT; i++) begin
      if (bit_start_i && !found && !busy_d[i]) begin
        busy_d[i] = 1'b1;
        cnt_d[i]  = ssp_i;
        found     = 1'b1;
      end
    end
  end

  assign rxb_en = |fire_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        cnt_q[i] <= '0;
      end
      rxb_q <= LVL_REC;
    end else begin
      busy_q <= busy_d;
      for (int i = 0; i < NSLOT; i++) begin
        cnt_q[i] <= cnt_d[i];
      end
      if (rxb_en) begin
        rxb_q <= rx_i;
      end
    end
  end

  assign stb_o    = |fire_c;
  assign rx_bit_o = rxb_q;
endmodule

// File: rtl/tdc_unit.sv
// Transmitter delay compensation top: measurement, position calculation
// and strobe scheduling.
module tdc_unit
  import tdc_pkg::*;
#(
  parameter int MEAS_W = 6,
  parameter int OFS_W  = 6,
  parameter int SPO_W  = 8,
  parameter int NSLOT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_i,
  input  logic              rx_i,
  input  logic              bit_start_i,
  input  logic [SPO_W-1:0]  sp_ofs_i,
  input  logic [1:0]        mode_i,
  input  logic [OFS_W-1:0]  tdc_ofs_i,
  output logic [MEAS_W-1:0] meas_o,
  output logic              meas_err_o,
  output logic              ssp_stb_o,
  output logic              rx_bit_o
);
  localparam int MAX_W = (SPO_W > MEAS_W) ? ((SPO_W > OFS_W) ? SPO_W : OFS_W)
                                          : ((MEAS_W > OFS_W) ? MEAS_W : OFS_W);
  localparam int SSP_W = MAX_W + 2;

  logic [MEAS_W-1:0] meas_w;
  logic [SSP_W-1:0]  ssp_w;

  tdc_meas #(.MEAS_W(MEAS_W)) u_meas (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_i        (tx_i),
    .rx_i        (rx_i),
    .bit_start_i (bit_start_i),
    .meas_o      (meas_w),
    .err_o       (meas_err_o)
  );

  tdc_ssp_calc #(.MEAS_W(MEAS_W), .OFS_W(OFS_W), .SPO_W(SPO_W)) u_calc (
    .mode_i (mode_i),
    .meas_i (meas_w),
    .ofs_i  (tdc_ofs_i),
    .spo_i  (sp_ofs_i),
    .ssp_o  (ssp_w)
  );

  tdc_ssp_sched #(.NSLOT(NSLOT), .CW(SSP_W)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_start_i (bit_start_i),
    .ssp_i       (ssp_w),
    .rx_i        (rx_i),
    .stb_o       (ssp_stb_o),
    .rx_bit_o    (rx_bit_o)
  );

  assign meas_o = meas_w;
endmodule

// File: rtl/tdc_unit_chk.sv
module tdc_unit_chk #(
  parameter int MEAS_W = 6,
  parameter int SPO_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_i,
  input logic              bit_start_i,
  input logic [SPO_W-1:0]  sp_ofs_i,
  input logic [1:0]        mode_i,
  input logic [MEAS_W-1:0] meas_o,
  input logic              meas_err_o,
  input logic              ssp_stb_o,
  input logic              rx_bit_o
);
  // R3
  meas_needs_rx_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(meas_o) |-> $past(rx_i == 1'b0));

  // R4
  timeout_keeps_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_err_o) |-> $stable(meas_o));

  // R4
  new_meas_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(meas_o) |-> !meas_err_o);

  // R11
  rx_bit_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_bit_o) |-> $past(ssp_stb_o));

  // R8
  off_zero_spo_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_start_i && mode_i == 2'b11 && sp_ofs_i == '0) |=> ssp_stb_o);
endmodule

bind tdc_unit tdc_unit_chk #(.MEAS_W(MEAS_W), .SPO_W(SPO_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_i        (rx_i),
  .bit_start_i (bit_start_i),
  .sp_ofs_i    (sp_ofs_i),
  .mode_i      (mode_i),
  .meas_o      (meas_o),
  .meas_err_o  (meas_err_o),
  .ssp_stb_o   (ssp_stb_o),
  .rx_bit_o    (rx_bit_o)
);

// File: tb/tdc_unit_tb.sv
module tdc_unit_tb;
  localparam int NSLOT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_i = 1'b1;
  logic       rx_i = 1'b1;
  logic       bit_start_i = 1'b0;
  logic [7:0] sp_ofs_i = '0;
  logic [1:0] mode_i = 2'b00;
  logic [5:0] tdc_ofs_i = '0;
  logic [5:0] meas_o;
  logic       meas_err_o;
  logic       ssp_stb_o;
  logic       rx_bit_o;

  always #2 clk = ~clk;

  tdc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tx_i(tx_i), .rx_i(rx_i),
    .bit_start_i(bit_start_i), .sp_ofs_i(sp_ofs_i), .mode_i(mode_i),
    .tdc_ofs_i(tdc_ofs_i), .meas_o(meas_o), .meas_err_o(meas_err_o),
    .ssp_stb_o(ssp_stb_o), .rx_bit_o(rx_bit_o)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string phase = "R1";

  // reference model state
  int m_meas, m_err, m_act, m_cnt, m_txq, m_rxbit;
  int pend[$];
  int gcyc = 0;
  logic hist[256];

  function automatic int model_ssp();
    int o_s, eff, tot;
    o_s = (tdc_ofs_i >= 6'd32) ? int'(tdc_ofs_i) - 64 : int'(tdc_ofs_i);
    case (mode_i)
      2'b00:   eff = m_meas + o_s;        // R6
      2'b01:   eff = int'(tdc_ofs_i);     // R7
      default: eff = 0;                   // R8
    endcase
    tot = eff + int'(sp_ofs_i);           // R9
    return (tot < 0) ? 0 : tot;
  endfunction

  task automatic model_reset();
    m_meas = 0; m_err = 0; m_act = 0; m_cnt = 0; m_txq = 1; m_rxbit = 1;
    pend.delete();
  endtask

  task automatic compare();
    int exp_stb;
    exp_stb = 0;
    foreach (pend[i]) if (pend[i] == 0) exp_stb = 1;
    n_vec += 4;
    if (int'(meas_o) != m_meas) begin
      n_bad++;
      $display("FAIL R3 (phase %s) meas_o got %0d expected %0d", phase, meas_o, m_meas);
    end
    if (int'(meas_err_o) != m_err) begin
      n_bad++;
      $display("FAIL R4 (phase %s) meas_err_o got %0d expected %0d", phase, meas_err_o, m_err);
    end
    if (int'(ssp_stb_o) != exp_stb) begin
      n_bad++;
      $display("FAIL R10 (phase %s) ssp_stb_o got %0d expected %0d at cycle %0d", phase, ssp_stb_o, exp_stb, gcyc);
    end
    if (int'(rx_bit_o) != m_rxbit) begin
      n_bad++;
      $display("FAIL R11 (phase %s) rx_bit_o got %0d expected %0d", phase, rx_bit_o, m_rxbit);
    end
  endtask

  // advance the model by one clock using the inputs now driven
  task automatic model_step();
    int nq[$];
    int fire, ssp;
    fire = 0;
    ssp = model_ssp();
    foreach (pend[i]) begin
      if (pend[i] == 0) fire = 1;
      else nq.push_back(pend[i] - 1);
    end
    if (fire) m_rxbit = int'(rx_i);                       // R11
    if (bit_start_i && nq.size() < NSLOT) nq.push_back(ssp); // R12
    pend = nq;
    if (bit_start_i && tx_i == 1'b0 && m_txq == 1) begin    // R2, R5
      if (rx_i == 1'b0) begin
        m_meas = 0; m_err = 0; m_act = 0;
      end else begin
        m_act = 1; m_cnt = 1;
      end
    end else if (m_act == 1) begin
      if (rx_i == 1'b0) begin
        m_meas = m_cnt; m_err = 0; m_act = 0;
      end else if (m_cnt == 63) begin
        m_err = 1; m_act = 0;
      end else begin
        m_cnt++;
      end
    end
    m_txq = int'(tx_i);
  endtask

  task automatic cyc(input logic bs, input logic tx, input logic rx);
    @(negedge clk);
    compare();
    bit_start_i = bs;
    tx_i = tx;
    rx_i = rx;
    model_step();
    gcyc++;
  endtask

  // drive bits; RX is TX delayed by dly cycles unless stuck recessive
  task automatic run_line(input int nbits, input int blen, input int dly,
                          input bit stuck, input logic [7:0] pat);
    for (int k = 0; k < nbits; k++) begin
      for (int j = 0; j < blen; j++) begin
        logic t, r;
        t = pat[k % 8];
        hist[gcyc % 256] = t;
        if (stuck) r = 1'b1;
        else if (dly == 0) r = t;
        else r = hist[(gcyc - dly + 256) % 256];
        cyc(j == 0, t, r);
      end
    end
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [5:0] o, input logic [7:0] s);
    @(negedge clk);
    compare();
    mode_i = m; tdc_ofs_i = o; sp_ofs_i = s;
    bit_start_i = 1'b0;
    model_step();
    hist[gcyc % 256] = tx_i;
    gcyc++;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) hist[i] = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state observed on idle cycles
    phase = "R1";
    run_line(1, 6, 0, 0, 8'hFF);
    // R3 / R6: automatic mode, zero offset, several loop delays
    phase = "R6";
    set_cfg(2'b00, 6'd0, 8'd10);
    run_line(12, 16, 5, 0, 8'b1011_0010);
    run_line(12, 16, 20, 0, 8'b1011_0010);
    // R6: negative offset moves the sample earlier
    set_cfg(2'b00, 6'h3D, 8'd2);
    run_line(12, 16, 7, 0, 8'b0110_1010);
    // R9: clamp of a negative position
    phase = "R9";
    set_cfg(2'b00, 6'h20, 8'd0);
    run_line(12, 16, 3, 0, 8'b1011_0010);
    // R7: manual value used directly
    phase = "R7";
    set_cfg(2'b01, 6'd40, 8'd5);
    run_line(12, 64, 2, 0, 8'b1011_0010);
    // R8: compensation off and reserved ignore the offset
    phase = "R8";
    set_cfg(2'b11, 6'd17, 8'd6);
    run_line(10, 16, 4, 0, 8'b1011_0010);
    set_cfg(2'b10, 6'd29, 8'd0);
    run_line(10, 16, 4, 0, 8'b1011_0010);
    // R4: timeout with RX stuck, then with an over-long delay
    phase = "R4";
    set_cfg(2'b00, 6'd0, 8'd3);
    run_line(6, 80, 0, 1, 8'b1011_0010);
    run_line(6, 80, 70, 0, 8'b1011_0010);
    // R3: zero loop delay clears the error
    phase = "R3";
    run_line(8, 16, 0, 0, 8'b1011_0010);
    // R2: TX held dominant across bit starts starts nothing
    phase = "R2";
    run_line(8, 16, 9, 0, 8'h00);
    run_line(4, 16, 9, 0, 8'hFF);
    // R5: restart while a measurement is still counting
    phase = "R5";
    run_line(16, 4, 10, 0, 8'b1010_1010);
    // R12: more pending strobes than slots
    phase = "R12";
    set_cfg(2'b00, 6'd31, 8'd200);
    run_line(120, 4, 1, 0, 8'b1011_0010);
    run_line(4, 300, 1, 0, 8'hFF);
    @(negedge clk);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule